// File: doc/BRIEF.md
# Variable-Page-Size Translation Lookaside Buffer

This block is the translation cache of a device-side memory management unit. It holds a small set of fully associative entries. Each entry pairs a tag word (virtual page tag, page-size code, valid flag, preserved flag) with a data word (physical page address and access attributes). Every entry carries its own page size: 16 MB, 1 MB, 64 KB or 4 KB. That size decides how many upper address bits take part in its compare, so pages of different sizes can sit side by side in the same buffer.

Control software fills the buffer through a small register-style port. It writes a lock word that sets a protected base index and a victim index, then presents a tag word and a data word with a load strobe. The entry is stored at the victim index and the victim index moves on, wrapping back to the base so that entries below the base are never replaced. A global flush or an address-matched flush invalidates entries, but preserved entries are kept. The entry at the victim index can be read back.

A combinational lookup port translates a virtual address. It reports a single hit together with the translated address and attributes, a miss when nothing matches, or a multi-hit fault when two or more valid entries match.

Top module: `vps_tlb`

## Requirements
- R1: After reset every entry is invalid, every lookup reports a miss, `lock_rdata`, `rd_tag`, `rd_data` and `ld_err` are zero, and `lk_pa` and the attribute outputs are zero.
- R2: A load stores `ld_tag` with bit 2 (valid) forced to 1 and stores `ld_data` unchanged at the victim index. `rd_tag`/`rd_data` show the entry at the current victim index, one clock after the victim index or that entry changes.
- R3: The page-size code in tag bits 1:0 is 0 = 1 MB, 1 = 64 KB, 2 = 4 KB, 3 = 16 MB. The compare covers address bits 31:20, 31:16, 31:12 and 31:24 respectively, against tag bits of the same positions. On a single hit, `lk_pa` is the data word's bits above the page boundary joined with `lk_va`'s bits below it.
- R4: On a single hit the attributes come from the data word: `lk_endian` = bit 5, `lk_elsz` = bits 4:3 (1 = 16-bit, 2 = 32-bit, 3 = none) and `lk_mixed` = bit 6. They are zero otherwise.
- R5: When two or more valid entries match `lk_va`, `lk_multi` is 1, `lk_hit` and `lk_miss` are 0, and `lk_pa` is zero.
- R6: When no valid entry matches, `lk_miss` is 1 and `lk_hit`, `lk_multi` and `lk_pa` are zero. Exactly one of the three flags is 1 at all times.
- R7: A load whose tag has a nonzero bit between bit 12 and its page boundary is rejected. Nothing is stored, the victim index does not move, and `ld_err` is 1 in the cycle after the strobe.
- R8: An accepted load advances the victim index by one. From the last index (`N_ENTRIES-1`) it wraps to the base index.
- R9: A write with `lock_we` sets the base index from `lock_wdata` bits 14:10 and the victim index from bits 8:4. `lock_rdata` returns them at the same positions, with all other bits zero.
- R10: `flush_all` clears the valid bit of every entry whose tag bit 3 (preserved) is 0 and leaves preserved entries unchanged.
- R11: `flush_one` clears the valid bit only of non-preserved entries that match `flush_va` under their own page size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Exactly one valid entry matches |
| lk_miss | output | 1 | No valid entry matches |
| lk_multi | output | 1 | Two or more valid entries match (fault) |
| lk_pa | output | 32 | Translated address on a hit, else zero |
| lk_endian | output | 1 | Endianness attribute of the hit entry |
| lk_elsz | output | 2 | Element-size attribute of the hit entry |
| lk_mixed | output | 1 | Mixed-attribute flag of the hit entry |
| ld_stb | input | 1 | Load strobe for the presented tag and data words |
| ld_tag | input | 32 | Tag word to load |
| ld_data | input | 32 | Data word to load |
| ld_err | output | 1 | Previous load was rejected as misaligned |
| lock_we | input | 1 | Write strobe for the lock word |
| lock_wdata | input | 32 | Lock word: base bits 14:10, victim bits 8:4 |
| lock_rdata | output | 32 | Current base and victim indices |
| flush_all | input | 1 | Invalidate all non-preserved entries |
| flush_one | input | 1 | Invalidate non-preserved entries matching flush_va |
| flush_va | input | 32 | Address for the single-entry flush |
| rd_tag | output | 32 | Tag word of the entry at the victim index |
| rd_data | output | 32 | Data word of the entry at the victim index |

## Verification
A corrupted entry or a wrong compare mask shows up at the lookup port in the same cycle, as a miss where a hit is due, a stray multi-hit fault, or wrong translated bits at the page boundary. A victim pointer that moves wrongly shows on `lock_rdata` right after the load. It also shows one cycle later on the read-back words, and later as an entry that was overwritten and now misses. Flush mistakes show as preserved entries that no longer hit or as flushed ones that still hit, on the first lookup after the flush.

// File: rtl/vps_tlb_pkg.sv
package vps_tlb_pkg;

  localparam int WORD_W   = 32;
  localparam int TAG_VLD  = 2;
  localparam int TAG_PRS  = 3;
  localparam int DAT_END  = 5;
  localparam int DAT_ESZ  = 3;
  localparam int DAT_MIX  = 6;
  localparam int LCK_BASE = 10;
  localparam int LCK_VICT = 4;

  typedef enum logic [1:0] {
    PG_1M  = 2'd0,
    PG_64K = 2'd1,
    PG_4K  = 2'd2,
    PG_16M = 2'd3
  } pg_code_e;

  function automatic logic [WORD_W-1:0] page_mask(input logic [1:0] pg);
    case (pg_code_e'(pg))
      PG_16M:  page_mask = 32'hFF00_0000;
      PG_1M:   page_mask = 32'hFFF0_0000;
      PG_64K:  page_mask = 32'hFFFF_0000;
      default: page_mask = 32'hFFFF_F000;
    endcase
  endfunction

  function automatic logic tag_hits(input logic [WORD_W-1:0] tag,
                                    input logic [WORD_W-1:0] va);
    tag_hits = tag[TAG_VLD] && (((tag ^ va) & page_mask(tag[1:0])) == '0);
  endfunction

endpackage

// File: rtl/vps_tlb_entry.sv
module vps_tlb_entry
  import vps_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_tag,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              flush_all,
  input  logic              flush_one,
  input  logic [WORD_W-1:0] flush_va,
  input  logic [WORD_W-1:0] lk_va,
  output logic [WORD_W-1:0] tag_o,
  output logic [WORD_W-1:0] data_o,
  output logic              lk_match_o
);

  logic [WORD_W-1:0] tag_q, data_q;
  logic              kill;

  assign kill = (flush_all || (flush_one && tag_hits(tag_q, flush_va))) && !tag_q[TAG_PRS];

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q  <= '0;
      data_q <= '0;
    end else if (wr_en) begin
      tag_q  <= wr_tag | (WORD_W'(1) << TAG_VLD);
      data_q <= wr_data;
    end else if (kill) begin
      tag_q[TAG_VLD] <= 1'b0;
    end
  end

  assign tag_o      = tag_q;
  assign data_o     = data_q;
  assign lk_match_o = tag_hits(tag_q, lk_va);

  // R2: a stored entry is always valid
  p_load_valid_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> tag_q[TAG_VLD]);

  // R10/R11: preserved entries survive any flush
  p_keep_locked_r10: assert property (@(posedge clk) disable iff (rst)
    ((flush_all || flush_one) && !wr_en && tag_q[TAG_PRS]) |=> $stable(tag_q));

  // R10: a global flush leaves no unpreserved valid entry
  p_flush_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (flush_all && !wr_en && !tag_q[TAG_PRS]) |=> !tag_q[TAG_VLD]);

endmodule

// File: rtl/vps_tlb_lockptr.sv
module vps_tlb_lockptr #(
  parameter int N_ENTRIES = 32,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_base,
  input  logic [IDX_W-1:0] set_vict,
  input  logic             adv,
  output logic [IDX_W-1:0] base_o,
  output logic [IDX_W-1:0] vict_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  logic [IDX_W-1:0] base_q, vict_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      vict_q <= '0;
    end else if (set_en) begin
      base_q <= set_base;
      vict_q <= set_vict;
    end else if (adv) begin
      vict_q <= (vict_q == LAST) ? base_q : vict_q + 1'b1;
    end
  end

  assign base_o = base_q;
  assign vict_o = vict_q;

  // R8: wrap from the last slot lands on the lock base
  p_wrap_base_r8: assert property (@(posedge clk) disable iff (rst)
    (adv && !set_en && vict_q == LAST) |=> (vict_q == $past(base_q)));

  // R8: victim index never moves without a load or a lock write
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!adv && !set_en) |=> $stable(vict_q) && $stable(base_q));

endmodule

// File: rtl/vps_tlb.sv
module vps_tlb
  import vps_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  localparam int IDX_W = $clog2(N_ENTRIES),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] lk_va,
  output logic        lk_hit,
  output logic        lk_miss,
  output logic        lk_multi,
  output logic [31:0] lk_pa,
  output logic        lk_endian,
  output logic [1:0]  lk_elsz,
  output logic        lk_mixed,
  input  logic        ld_stb,
  input  logic [31:0] ld_tag,
  input  logic [31:0] ld_data,
  output logic        ld_err,
  input  logic        lock_we,
  input  logic [31:0] lock_wdata,
  output logic [31:0] lock_rdata,
  input  logic        flush_all,
  input  logic        flush_one,
  input  logic [31:0] flush_va,
  output logic [31:0] rd_tag,
  output logic [31:0] rd_data
);

  logic [WORD_W-1:0] ent_tag  [N_ENTRIES];
  logic [WORD_W-1:0] ent_data [N_ENTRIES];
  logic [N_ENTRIES-1:0] lk_match;
  logic [IDX_W-1:0]  base_idx, vict_idx;
  logic              ld_ok, ld_go;
  logic              err_q;
  logic [WORD_W-1:0] rd_tag_q, rd_data_q;
  logic              unused_lock;

  // Load alignment: bits between 12 and the page boundary must be zero
  assign ld_ok = ((ld_tag & ~page_mask(ld_tag[1:0]) & 32'hFFFF_F000) == '0);
  assign ld_go = ld_stb && ld_ok;

  vps_tlb_lockptr #(.N_ENTRIES(N_ENTRIES)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .set_en   (lock_we),
    .set_base (lock_wdata[LCK_BASE +: IDX_W]),
    .set_vict (lock_wdata[LCK_VICT +: IDX_W]),
    .adv      (ld_go),
    .base_o   (base_idx),
    .vict_o   (vict_idx)
  );

  assign unused_lock = ^{lock_wdata[31:LCK_BASE+IDX_W],
                         lock_wdata[LCK_BASE-1:LCK_VICT+IDX_W],
                         lock_wdata[LCK_VICT-1:0]};

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    vps_tlb_entry u_ent (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (ld_go && (vict_idx == IDX_W'(g))),
      .wr_tag     (ld_tag),
      .wr_data    (ld_data),
      .flush_all  (flush_all),
      .flush_one  (flush_one),
      .flush_va   (flush_va),
      .lk_va      (lk_va),
      .tag_o      (ent_tag[g]),
      .data_o     (ent_data[g]),
      .lk_match_o (lk_match[g])
    );
  end

  // Match reduction: count and OR-merge; the merge is exact for a single hit
  logic [CNT_W-1:0]  hit_cnt;
  logic [WORD_W-1:0] sel_tag, sel_data, sel_mask;

  always_comb begin
    hit_cnt  = '0;
    sel_tag  = '0;
    sel_data = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (lk_match[i]) begin
        hit_cnt  = hit_cnt + 1'b1;
        sel_tag  = sel_tag | ent_tag[i];
        sel_data = sel_data | ent_data[i];
      end
    end
  end

  assign sel_mask  = page_mask(sel_tag[1:0]);
  assign lk_hit    = (hit_cnt == CNT_W'(1));
  assign lk_miss   = (hit_cnt == '0);
  assign lk_multi  = (hit_cnt > CNT_W'(1));
  assign lk_pa     = lk_hit ? ((sel_data & sel_mask) | (lk_va & ~sel_mask)) : '0;
  assign lk_endian = lk_hit && sel_data[DAT_END];
  assign lk_elsz   = lk_hit ? sel_data[DAT_ESZ +: 2] : 2'b00;
  assign lk_mixed  = lk_hit && sel_data[DAT_MIX];

  always_comb begin
    lock_rdata = '0;
    lock_rdata[LCK_BASE +: IDX_W] = base_idx;
    lock_rdata[LCK_VICT +: IDX_W] = vict_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q     <= 1'b0;
      rd_tag_q  <= '0;
      rd_data_q <= '0;
    end else begin
      err_q     <= ld_stb && !ld_ok;
      rd_tag_q  <= ent_tag[vict_idx];
      rd_data_q <= ent_data[vict_idx];
    end
  end

  assign ld_err  = err_q;
  assign rd_tag  = rd_tag_q;
  assign rd_data = rd_data_q;

  // R5/R6: lookup reports exactly one outcome
  p_one_outcome_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot({lk_hit, lk_miss, lk_multi}));

  // R3: offset bits pass through untranslated on a hit
  p_offset_pass_r3: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_pa[11:0] == lk_va[11:0]));

  // R7: a rejected load leaves the victim index alone
  p_misalign_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (ld_stb && !ld_ok && !lock_we) |=> $stable(vict_idx));

  // R7: error flag only follows a load strobe
  p_err_source_r7: assert property (@(posedge clk) disable iff (rst)
    ld_err |-> $past(ld_stb));

endmodule

// File: tb/vps_tlb_tb.sv
module vps_tlb_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] lk_va;
  logic        lk_hit, lk_miss, lk_multi;
  logic [31:0] lk_pa;
  logic        lk_endian, lk_mixed;
  logic [1:0]  lk_elsz;
  logic        ld_stb;
  logic [31:0] ld_tag, ld_data;
  logic        ld_err;
  logic        lock_we;
  logic [31:0] lock_wdata, lock_rdata;
  logic        flush_all, flush_one;
  logic [31:0] flush_va;
  logic [31:0] rd_tag, rd_data;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  vps_tlb u_dut (
    .clk(clk), .rst(rst), .lk_va(lk_va), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_multi(lk_multi), .lk_pa(lk_pa), .lk_endian(lk_endian), .lk_elsz(lk_elsz),
    .lk_mixed(lk_mixed), .ld_stb(ld_stb), .ld_tag(ld_tag), .ld_data(ld_data),
    .ld_err(ld_err), .lock_we(lock_we), .lock_wdata(lock_wdata),
    .lock_rdata(lock_rdata), .flush_all(flush_all), .flush_one(flush_one),
    .flush_va(flush_va), .rd_tag(rd_tag), .rd_data(rd_data)
  );

  // {va, flags{0,hit,miss,multi}, pa, attr{endian,elsz,mixed}}
  localparam logic [71:0] VEC [0:7] = '{
    {32'h12AB_CDEF, 4'b0100, 32'h8AAB_CDEF, 4'b1100},
    {32'h345F_FFFF, 4'b0100, 32'h567F_FFFF, 4'b0001},
    {32'h7FFF_1234, 4'b0100, 32'h1122_1234, 4'b0010},
    {32'hABCD_E7FF, 4'b0100, 32'h0123_47FF, 4'b0000},
    {32'hABCD_F000, 4'b0010, 32'h0000_0000, 4'b0000},
    {32'h1234_5678, 4'b0001, 32'h0000_0000, 4'b0000},
    {32'hC000_1FFF, 4'b0100, 32'h2222_2FFF, 4'b0000},
    {32'h0000_0000, 4'b0010, 32'h0000_0000, 4'b0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] t, input logic [31:0] d);
    @(negedge clk);
    ld_stb = 1'b1; ld_tag = t; ld_data = d;
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic set_lock(input int base, input int vict);
    @(negedge clk);
    lock_we = 1'b1;
    lock_wdata = (32'(base) << 10) | (32'(vict) << 4);
    @(negedge clk);
    lock_we = 1'b0;
  endtask

  task automatic pulse_flush(input bit all, input logic [31:0] va);
    @(negedge clk);
    flush_all = all; flush_one = !all; flush_va = va;
    @(negedge clk);
    flush_all = 1'b0; flush_one = 1'b0;
  endtask

  task automatic look(input logic [31:0] va);
    lk_va = va;
    #1;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; lk_va = '0; ld_stb = 0; ld_tag = '0; ld_data = '0;
    lock_we = 0; lock_wdata = '0; flush_all = 0; flush_one = 0; flush_va = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    look(32'h1200_0000);
    chk("R1 miss", 32'(lk_miss), 32'd1);
    chk("R1 pa", lk_pa, 32'd0);
    chk("R1 lock", lock_rdata, 32'd0);
    chk("R1 rd_tag", rd_tag, 32'd0);
    chk("R1 ld_err", 32'(ld_err), 32'd0);

    // Fill entries 0..5 (16M, 1M, 64K, 4K, 4K overlapping, preserved 4K)
    load(32'h1200_0003, 32'h8A00_0030);
    load(32'h3450_0000, 32'h5670_0040);
    load(32'h7FFF_0001, 32'h1122_0008);
    load(32'hABCD_E002, 32'h0123_4000);
    load(32'h1234_5002, 32'h0FEE_D000);
    load(32'hC000_100A, 32'h2222_2000);
    chk("R8 advance", lock_rdata, 32'h0000_0060);

    // Table of lookups: R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      look(VEC[i][71:40]);
      chk("R3/R5/R6 flags", {29'd0, lk_hit, lk_miss, lk_multi}, 32'(VEC[i][38:36]));
      chk("R3 pa", lk_pa, VEC[i][35:4]);
      chk("R4 attr", {28'd0, lk_endian, lk_elsz, lk_mixed}, 32'(VEC[i][3:0]));
    end

    // R2: read-back at victim, valid forced
    set_lock(0, 3);
    @(negedge clk);
    chk("R2 rd_tag", rd_tag, 32'hABCD_E006);
    chk("R2 rd_data", rd_data, 32'h0123_4000);

    // R7: misaligned 64K load rejected
    set_lock(0, 6);
    load(32'h0000_1001, 32'h3333_0000);
    chk("R7 ld_err", 32'(ld_err), 32'd1);
    chk("R7 victim held", lock_rdata, 32'h0000_0060);
    look(32'h0000_1000);
    chk("R7 not stored", 32'(lk_miss), 32'd1);
    @(negedge clk);
    chk("R7 err clears", 32'(ld_err), 32'd0);

    // R9 and R8 wrap to base
    set_lock(30, 31);
    chk("R9 lock fields", lock_rdata, 32'h0000_79F0);
    load(32'h4000_0000, 32'h9000_0000);
    chk("R8 wrap", lock_rdata, 32'h0000_79E0);
    load(32'h5000_0000, 32'hA000_0000);
    chk("R8 next", lock_rdata, 32'h0000_79F0);
    look(32'h4001_2345);
    chk("R8 entry31", lk_pa, 32'h9001_2345);
    look(32'h500A_BCDE);
    chk("R8 entry30", lk_pa, 32'hA00A_BCDE);
    look(32'h3451_0000);
    chk("R8 low kept", lk_pa, 32'h5671_0000);

    // R11: single flush
    pulse_flush(1'b0, 32'h7FFF_0000);
    look(32'h7FFF_1234);
    chk("R11 flushed", 32'(lk_miss), 32'd1);
    look(32'h345F_FFFF);
    chk("R11 other kept", 32'(lk_hit), 32'd1);
    pulse_flush(1'b0, 32'hC000_1000);
    look(32'hC000_1FFF);
    chk("R11 preserved", lk_pa, 32'h2222_2FFF);

    // R10: global flush
    pulse_flush(1'b1, 32'h0);
    look(32'h1234_5678);
    chk("R10 cleared", 32'(lk_miss), 32'd1);
    look(32'h4001_2345);
    chk("R10 cleared2", 32'(lk_miss), 32'd1);
    look(32'hC000_1004);
    chk("R10 preserved", lk_pa, 32'h2222_2004);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule